// File: doc/BRIEF.md
# Shared Code and Data Word Store

This block is the main store of a small two-operand processor. It holds 256 words of 32 bits. Each word is an instruction, and the low byte of each word is also a data cell that the program can read and write. Each cycle the block serves three reads at once. The first is the whole word at the program counter. The other two are the low bytes at the two operand addresses that the current instruction names.

A single byte-wide write lands on the next rising clock edge. Two control bits choose its address: the first-operand address or the second-operand address. When both bits are set, the processor treats the instruction as a halt and nothing is written. The low byte of a word is also the second-operand address field of the instruction stored there. A data write therefore rewrites that instruction's target field. Programs use this for indexing and for return linkage.

A load port writes full 32-bit words, and it is honoured only while the processor is held in reset. It is used to put a program in place before execution starts.

Top module: `shared_word_mem`

## Requirements
- R1: `instr_word` always equals the full 32-bit word stored at `pc_addr`, with no clock delay.
- R2: `opa_byte` equals bits [7:0] of the word at `opa_addr`, and `opb_byte` equals bits [7:0] of the word at `opb_addr`, with no clock delay.
- R3: Outside reset, with `wr_sel_b`=1 and `wr_sel_a`=0, a rising edge replaces bits [7:0] of the word at `opb_addr` with `wr_byte`. Bits [31:8] of that word keep their value.
- R4: Outside reset, with `wr_sel_a`=1 and `wr_sel_b`=0, a rising edge replaces bits [7:0] of the word at `opa_addr` with `wr_byte`. Bits [31:8] of that word keep their value.
- R5: With both `wr_sel_a` and `wr_sel_b` at 1 (the halt encoding), no word changes.
- R6: A read of an address that is being written in the same cycle returns the stored value from before the write. The new value appears only after the edge.
- R7: While `rst` is 1, `wr_sel_a` and `wr_sel_b` have no effect. A rising edge with `load_en`=1 stores all 32 bits of `load_word` at `load_addr`.
- R8: While `rst` is 0, `load_en` has no effect on any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and loads take effect on its rising edge |
| rst | input | 1 | Processor reset; selects load mode and blocks program writes |
| pc_addr | input | 8 | Address of the instruction word to read |
| instr_word | output | 32 | Full word at `pc_addr` |
| opa_addr | input | 8 | First-operand address field of the current instruction |
| opb_addr | input | 8 | Second-operand address field of the current instruction |
| opa_byte | output | 8 | Low byte of the word at `opa_addr` |
| opb_byte | output | 8 | Low byte of the word at `opb_addr` |
| wr_sel_a | input | 1 | Write result byte to `opa_addr` |
| wr_sel_b | input | 1 | Write result byte to `opb_addr` |
| wr_byte | input | 8 | Result byte to write |
| load_en | input | 1 | Full-word load strobe, honoured only in reset |
| load_addr | input | 8 | Address for a full-word load |
| load_word | input | 32 | Word to load |

## Verification
The assertions assume that `rst` is driven to 1 from time zero. They also assume that every control and address input holds a known value at each rising edge. The write checks look only at cycles where `pc_addr` names the written word and stays the same into the following cycle. Some cycles break that pattern, for example when the bench moves the program counter between tests. The checks pass over those cycles without judging them.

The stimulus holds reset throughout the full-image load. It changes inputs only on falling edges. It keeps `pc_addr` on the target word from the write cycle until after the following check.

// File: rtl/swm_pkg.sv
package swm_pkg;

   // Write target decoded from the two select bits {a, b}
   typedef enum logic [1:0] {
      WS_NONE = 2'b00,
      WS_B    = 2'b01,
      WS_A    = 2'b10,
      WS_HALT = 2'b11
   } wr_sel_e;

   function automatic wr_sel_e decode_sel(input logic sel_a, input logic sel_b);
      return wr_sel_e'({sel_a, sel_b});
   endfunction

endpackage

// File: rtl/swm_wctl.sv
module swm_wctl #(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 32,
   parameter int DATA_W = 8,
   localparam int HI_W  = WORD_W - DATA_W
) (
   input  logic              rst,
   input  logic              wr_sel_a,
   input  logic              wr_sel_b,
   input  logic [ADDR_W-1:0] opa_addr,
   input  logic [ADDR_W-1:0] opb_addr,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [WORD_W-1:0] load_word,
   output logic              lo_we,
   output logic [ADDR_W-1:0] lo_waddr,
   output logic [DATA_W-1:0] lo_wdata,
   output logic              hi_we,
   output logic [ADDR_W-1:0] hi_waddr,
   output logic [HI_W-1:0]   hi_wdata
);
   import swm_pkg::*;

   wr_sel_e sel;

   always_comb begin
      sel      = decode_sel(wr_sel_a, wr_sel_b);
      lo_we    = 1'b0;
      lo_waddr = opb_addr;
      lo_wdata = wr_byte;
      hi_we    = 1'b0;
      hi_waddr = load_addr;
      hi_wdata = load_word[WORD_W-1:DATA_W];
      if (rst) begin
         // load mode: full word, program writes blocked
         lo_we    = load_en;
         lo_waddr = load_addr;
         lo_wdata = load_word[DATA_W-1:0];
         hi_we    = load_en;
      end else begin
         unique case (sel)
            WS_A:    begin lo_we = 1'b1; lo_waddr = opa_addr; end
            WS_B:    begin lo_we = 1'b1; lo_waddr = opb_addr; end
            default: lo_we = 1'b0;   // none, or halt encoding
         endcase
      end
   end

endmodule

// File: rtl/swm_lane.sv
module swm_lane #(
   parameter int W      = 8,
   parameter int ADDR_W = 8,
   parameter int NRD    = 1,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic                        clk,
   input  logic                        we,
   input  logic [ADDR_W-1:0]           waddr,
   input  logic [W-1:0]                wdata,
   input  logic [NRD-1:0][ADDR_W-1:0]  raddr,
   output logic [NRD-1:0][W-1:0]       rdata
);
   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = cells[raddr[g]];
   end

endmodule

// File: rtl/shared_word_mem.sv
module shared_word_mem #(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 32,
   parameter int DATA_W = 8,
   localparam int HI_W  = WORD_W - DATA_W,
   localparam int NLO   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] pc_addr,
   output logic [WORD_W-1:0] instr_word,
   input  logic [ADDR_W-1:0] opa_addr,
   input  logic [ADDR_W-1:0] opb_addr,
   output logic [DATA_W-1:0] opa_byte,
   output logic [DATA_W-1:0] opb_byte,
   input  logic              wr_sel_a,
   input  logic              wr_sel_b,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [WORD_W-1:0] load_word
);
   if (DATA_W < 1 || DATA_W >= WORD_W) begin : g_bad_width
      $error("DATA_W must be at least 1 and below WORD_W");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end

   logic              lo_we, hi_we;
   logic [ADDR_W-1:0] lo_waddr, hi_waddr;
   logic [DATA_W-1:0] lo_wdata;
   logic [HI_W-1:0]   hi_wdata;

   swm_wctl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_wctl (
      .rst(rst), .wr_sel_a(wr_sel_a), .wr_sel_b(wr_sel_b),
      .opa_addr(opa_addr), .opb_addr(opb_addr), .wr_byte(wr_byte),
      .load_en(load_en), .load_addr(load_addr), .load_word(load_word),
      .lo_we(lo_we), .lo_waddr(lo_waddr), .lo_wdata(lo_wdata),
      .hi_we(hi_we), .hi_waddr(hi_waddr), .hi_wdata(hi_wdata)
   );

   // data lane: three read ports (pc, operand a, operand b)
   logic [NLO-1:0][ADDR_W-1:0] lo_raddr;
   logic [NLO-1:0][DATA_W-1:0] lo_rdata;
   assign lo_raddr = {opb_addr, opa_addr, pc_addr};

   swm_lane #(.W(DATA_W), .ADDR_W(ADDR_W), .NRD(NLO)) u_lo (
      .clk(clk), .we(lo_we), .waddr(lo_waddr), .wdata(lo_wdata),
      .raddr(lo_raddr), .rdata(lo_rdata)
   );

   // instruction-only lane: one read port, written by load alone
   logic [0:0][ADDR_W-1:0] hi_raddr;
   logic [0:0][HI_W-1:0]   hi_rdata;
   assign hi_raddr[0] = pc_addr;

   swm_lane #(.W(HI_W), .ADDR_W(ADDR_W), .NRD(1)) u_hi (
      .clk(clk), .we(hi_we), .waddr(hi_waddr), .wdata(hi_wdata),
      .raddr(hi_raddr), .rdata(hi_rdata)
   );

   assign instr_word = {hi_rdata[0], lo_rdata[0]};
   assign opa_byte   = lo_rdata[1];
   assign opb_byte   = lo_rdata[2];

endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 32,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] pc_addr,
   input logic [WORD_W-1:0] instr_word,
   input logic [ADDR_W-1:0] opa_addr,
   input logic [ADDR_W-1:0] opb_addr,
   input logic [DATA_W-1:0] opa_byte,
   input logic [DATA_W-1:0] opb_byte,
   input logic              wr_sel_a,
   input logic              wr_sel_b,
   input logic [DATA_W-1:0] wr_byte,
   input logic              load_en,
   input logic [ADDR_W-1:0] load_addr
);
   // R2
   rd_port_agree_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_addr == opb_addr) |-> (opb_byte == instr_word[DATA_W-1:0]));

   // R3
   wr_b_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_sel_b && !wr_sel_a && pc_addr == opb_addr)
      |=> ((pc_addr != $past(pc_addr)) ||
           (instr_word == {$past(instr_word[WORD_W-1:DATA_W]), $past(wr_byte)})));

   // R4
   wr_a_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_sel_a && !wr_sel_b && pc_addr == opa_addr)
      |=> ((pc_addr != $past(pc_addr)) ||
           (instr_word == {$past(instr_word[WORD_W-1:DATA_W]), $past(wr_byte)})));

   // R5
   halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_sel_a && wr_sel_b)
      |=> ((pc_addr != $past(pc_addr)) || $stable(instr_word)));

   // R8
   load_blocked_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && !wr_sel_a && !wr_sel_b && load_addr == pc_addr)
      |=> ((pc_addr != $past(pc_addr)) || $stable(instr_word)));

endmodule

bind shared_word_mem swm_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_swm_chk (
   .clk(clk), .rst(rst), .pc_addr(pc_addr), .instr_word(instr_word),
   .opa_addr(opa_addr), .opb_addr(opb_addr), .opa_byte(opa_byte), .opb_byte(opb_byte),
   .wr_sel_a(wr_sel_a), .wr_sel_b(wr_sel_b), .wr_byte(wr_byte),
   .load_en(load_en), .load_addr(load_addr)
);

// File: tb/shared_word_mem_bench.sv
module shared_word_mem_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  pc_addr = '0, opa_addr = '0, opb_addr = '0, wr_byte = '0, load_addr = '0;
   logic        wr_sel_a = 1'b0, wr_sel_b = 1'b0, load_en = 1'b0;
   logic [31:0] load_word = '0;
   logic [31:0] instr_word;
   logic [7:0]  opa_byte, opb_byte;

   int total = 0;
   int bad = 0;
   logic [31:0] mdl [256];

   always #(CLK_P/2) clk = ~clk;

   shared_word_mem u_shared_word_mem (
      .clk(clk), .rst(rst), .pc_addr(pc_addr), .instr_word(instr_word),
      .opa_addr(opa_addr), .opb_addr(opb_addr), .opa_byte(opa_byte), .opb_byte(opb_byte),
      .wr_sel_a(wr_sel_a), .wr_sel_b(wr_sel_b), .wr_byte(wr_byte),
      .load_en(load_en), .load_addr(load_addr), .load_word(load_word)
   );

   // {mode[1:0] (0 none, 1 a, 2 b, 3 both), a addr, b addr, byte}
   localparam logic [25:0] VEC [8] = '{
      {2'd2, 8'd10,  8'd20,  8'hAA},
      {2'd1, 8'd30,  8'd40,  8'h55},
      {2'd3, 8'd50,  8'd60,  8'hFF},
      {2'd2, 8'd70,  8'd70,  8'h11},
      {2'd1, 8'd255, 8'd0,   8'h80},
      {2'd2, 8'd1,   8'd255, 8'h7F},
      {2'd0, 8'd5,   8'd6,   8'h33},
      {2'd1, 8'd0,   8'd0,   8'hC3}
   };

   function automatic logic [31:0] seed(input int i);
      return {8'(i*37+11), 8'(i ^ 8'hC3), 8'(255-i), 8'(i*5+2)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   initial begin
      #(CLK_P*100000);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // load full image while in reset (R7)
      @(negedge clk);
      for (int i = 0; i < 256; i++) begin
         load_en = 1'b1; load_addr = 8'(i); load_word = seed(i);
         mdl[i] = seed(i);
         @(negedge clk);
      end
      load_en = 1'b0;
      #1;
      // reset state: full words present (R1, R7)
      pc_addr = 8'd0;   #1; check("R7 load word 0", instr_word, mdl[0]);
      pc_addr = 8'd255; #1; check("R1 word 255", instr_word, mdl[255]);
      opa_addr = 8'd17; opb_addr = 8'd200; #1;
      check("R2 a byte", {24'd0, opa_byte}, {24'd0, mdl[17][7:0]});
      check("R2 b byte", {24'd0, opb_byte}, {24'd0, mdl[200][7:0]});

      // R7: program write ignored in reset
      pc_addr = 8'd20; opb_addr = 8'd20; wr_sel_b = 1'b1; wr_byte = 8'h99;
      tick();
      check("R7 write blocked in reset", instr_word, mdl[20]);
      wr_sel_b = 1'b0;

      @(negedge clk);
      rst = 1'b0;

      foreach (VEC[k]) begin
         logic [1:0] mode;
         logic [7:0] va, vb, vd, tgt;
         {mode, va, vb, vd} = VEC[k];
         tgt = (mode == 2'd1) ? va : vb;
         opa_addr = va; opb_addr = vb; wr_byte = vd; pc_addr = tgt;
         wr_sel_a = mode[0]; wr_sel_b = mode[1];
         #1;
         check("R6 old value before edge", instr_word, mdl[tgt]);
         check("R2 a byte", {24'd0, opa_byte}, {24'd0, mdl[va][7:0]});
         check("R2 b byte", {24'd0, opb_byte}, {24'd0, mdl[vb][7:0]});
         if (mode == 2'd1) mdl[va][7:0] = vd;
         if (mode == 2'd2) mdl[vb][7:0] = vd;
         tick();
         case (mode)
            2'd1:    check("R4 write to a, upper kept", instr_word, mdl[tgt]);
            2'd2:    check("R3 write to b, upper kept", instr_word, mdl[tgt]);
            2'd3:    check("R5 halt no write", instr_word, mdl[tgt]);
            default: check("R1 no write", instr_word, mdl[tgt]);
         endcase
         wr_sel_a = 1'b0; wr_sel_b = 1'b0;
      end

      // R5: halt encoding must not touch the a target either
      pc_addr = 8'd50; #1;
      check("R5 halt a target", instr_word, mdl[50]);

      // R8: load ignored out of reset
      pc_addr = 8'd33; load_addr = 8'd33; load_word = 32'hDEADBEEF; load_en = 1'b1;
      tick();
      load_en = 1'b0;
      check("R8 load blocked", instr_word, mdl[33]);

      // R7: reset again and load one word
      rst = 1'b1;
      pc_addr = 8'd40; load_addr = 8'd40; load_word = 32'h12345678; load_en = 1'b1;
      tick();
      load_en = 1'b0;
      check("R7 full word load", instr_word, 32'h12345678);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule